// File: doc/BRIEF.md
# Multichannel DMA Channel Controller

This block keeps the programming state of several DMA channels and turns a peripheral's transfer request into a single memory transfer command. Software programs each channel through a 32-bit register port. A channel has four word slots: a spare word, a mode word, a byte count and a start address. A peripheral then names a channel, a direction and a length on the request port. The controller clears the channel's status flags and checks that the channel is enabled and that its programmed direction matches the request. If the check fails, it records an error. If it passes, it issues one command whose length is the smaller of the requested length and the remaining count. It then waits for the done strobe, after which it decrements the count and sets the terminal-count flag. The data bytes themselves move elsewhere.

Control is a three-state sequencer. IDLE holds `req_ready` high. The IDLE to CHECK transition fires when a request is accepted; on that edge the channel's flags are cleared. CHECK is a single cycle. It takes the CHECK to IDLE (reject) transition on a disabled channel or a direction mismatch, which raises the memory-error flag and the channel's bit in the error summary word. Otherwise it takes the CHECK to BUSY (issue) transition and latches the command fields. BUSY drives `cmd_valid` and takes the BUSY to IDLE (complete) transition when `cmd_done` is seen.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset every channel slot and the error summary read 0, `req_ready` is 1 and `cmd_valid` is 0.
- R2: Channel n slot k is read and written at byte offset 0x100 + n*0x20 + k*8 (slot 1 mode, slot 2 count, slot 3 address, slot 0 spare); address bits [1:0] are ignored, and reads are combinational from `reg_addr`.
- R3: The error summary reads at offset 0x200 (bit n for channel n, upper bits 0); writes to it have no effect.
- R4: Unmapped offsets, including channel-window offsets with bit 2 set and offsets past the last channel, read 0, and writes to them change no register.
- R5: Accepting a request clears mode bits 8 (terminal count), 9 (memory error) and 10 (address error) of the requested channel, leaving the other mode bits as they were.
- R6: If mode bit 0 (enable) is 0, or mode bit 1 (1 = memory-to-device, 0 = device-to-memory) differs from `req_dir` (same encoding), then mode bit 9 and summary bit n are set and no command is issued.
- R7: On a passing check, `cmd_valid` rises on the second rising edge after acceptance, with `cmd_chan`, `cmd_dir`, `cmd_addr` = address slot and `cmd_len` = min(`req_len`, count slot), and it holds all of them stable until `cmd_done`.
- R8: On `cmd_done`, mode bit 8 is set, the count slot drops by `cmd_len`, the address slot is unchanged, and `cmd_valid` falls on that edge.
- R9: `req_ready` is 0 from the accepting edge until the sequencer returns to IDLE, either after a reject or after the done strobe.
- R10: Summary bits are sticky: once set they stay set, and only reset clears them.
- R11: A register-port write to a channel slot in the same cycle as a sequencer update of that slot stores the written value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_chan | input | CH_W | Requested channel |
| req_dir | input | 1 | 1 = memory-to-device, 0 = device-to-memory |
| req_len | input | DATA_W | Requested length in bytes |
| cmd_valid | output | 1 | Memory transfer command outstanding |
| cmd_chan | output | CH_W | Channel of the command |
| cmd_dir | output | 1 | Direction of the command |
| cmd_addr | output | DATA_W | Start address of the command |
| cmd_len | output | DATA_W | Clamped length of the command |
| cmd_done | input | 1 | Completion strobe for the outstanding command |

## Verification
The completion update can land in the same cycle as a software write to the slot it modifies. The bench raises `cmd_done` on the same falling edge on which it starts a register write, once to the count slot and once to the mode slot. It expects the written word to read back exactly, with no decrement and no terminal-count bit merged into it. In the mode-slot case, the count slot, which was not written, must still show the decrement. Across a sweep of every channel, enable value, programmed direction, requested direction and clamping case, the bench also confirms that rejects and completions never disturb other registers.

// File: rtl/dmacc_pkg.sv
package dmacc_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_BUSY  = 2'd2
    } seq_state_e;

    // Register slot numbering inside a channel
    localparam int NUM_SLOTS  = 4;
    localparam int SLOT_SPARE = 0;
    localparam int SLOT_MODE  = 1;
    localparam int SLOT_COUNT = 2;
    localparam int SLOT_ADDR  = 3;

    // Address layout
    localparam int CH_BASE_OFF = 'h100;
    localparam int CH_STRIDE   = 'h20;
    localparam int SUM_OFF     = 'h200;
    localparam int CH_SHIFT    = 5;
    localparam int SLOT_SHIFT  = 3;

    // Mode word bit positions
    localparam int MODE_EN_BIT   = 0;
    localparam int MODE_DIR_BIT  = 1;
    localparam int FLAG_TC_BIT   = 8;
    localparam int FLAG_MERR_BIT = 9;
    localparam int FLAG_AERR_BIT = 10;

    // Hardware update requested of one channel
    typedef struct packed {
        logic clr_flags;
        logic set_merr;
        logic finish;
    } hw_op_t;

endpackage

// File: rtl/dmacc_addr_dec.sv
module dmacc_addr_dec
    import dmacc_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 12,
    parameter int CH_W   = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              chan_hit,
    output logic [CH_W-1:0]   chan,
    output logic [1:0]        slot,
    output logic              sum_hit
);

    localparam logic [ADDR_W-1:0] BASE   = ADDR_W'(CH_BASE_OFF);
    localparam logic [ADDR_W-1:0] WINDOW = ADDR_W'(NUM_CH * CH_STRIDE);
    localparam logic [ADDR_W-1:0] SUMA   = ADDR_W'(SUM_OFF);
    localparam logic [ADDR_W-1:0] WMASK  = ~ADDR_W'(3);

    logic [ADDR_W-1:0] word;
    logic [ADDR_W-1:0] off;

    always_comb begin
        word     = addr & WMASK;
        off      = word - BASE;
        chan_hit = (word >= BASE) && (off < WINDOW) && !off[2];
        chan     = off[CH_SHIFT +: CH_W];
        slot     = off[SLOT_SHIFT +: 2];
        sum_hit  = (word == SUMA);
    end

endmodule

// File: rtl/dmacc_chan_regs.sv
module dmacc_chan_regs
    import dmacc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              sw_we,
    input  logic [1:0]                        sw_slot,
    input  logic [DATA_W-1:0]                 sw_data,
    input  hw_op_t                            op,
    input  logic [DATA_W-1:0]                 sub_len,
    output logic [NUM_SLOTS-1:0][DATA_W-1:0]  slots
);

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        logic [DATA_W-1:0] q;
        logic [DATA_W-1:0] nxt;

        if (k == SLOT_MODE) begin : g_mode
            always_comb begin
                nxt = q;
                if (op.clr_flags) nxt[FLAG_AERR_BIT:FLAG_TC_BIT] = '0;
                if (op.set_merr)  nxt[FLAG_MERR_BIT] = 1'b1;
                if (op.finish)    nxt[FLAG_TC_BIT]   = 1'b1;
            end
        end else if (k == SLOT_COUNT) begin : g_count
            always_comb begin
                nxt = op.finish ? (q - sub_len) : q;
            end
        end else begin : g_plain
            always_comb begin
                nxt = q;
            end
        end

        // Software write takes precedence over the hardware update
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (sw_we && (sw_slot == 2'(k))) begin
                q <= sw_data;
            end else begin
                q <= nxt;
            end
        end

        assign slots[k] = q;
    end

endmodule

// File: rtl/dmacc_seq.sv
module dmacc_seq
    import dmacc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CH_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CH_W-1:0]   req_chan,
    input  logic              req_dir,
    input  logic [DATA_W-1:0] req_len,
    input  logic              cmd_done,
    input  logic [1:0]        sel_mode,
    input  logic [DATA_W-1:0] sel_count,
    input  logic [DATA_W-1:0] sel_addr,
    output logic              req_ready,
    output logic              cmd_valid,
    output logic [CH_W-1:0]   cmd_chan,
    output logic              cmd_dir,
    output logic [DATA_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_len,
    output logic [CH_W-1:0]   op_chan,
    output hw_op_t            op,
    output logic              err_pulse
);

    seq_state_e        state_q, state_d;
    logic [CH_W-1:0]   chan_q;
    logic              dir_q;
    logic [DATA_W-1:0] len_q;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] xlen_q;
    logic              reject;
    logic [DATA_W-1:0] clamp_len;

    always_comb begin
        reject    = !sel_mode[MODE_EN_BIT] || (sel_mode[MODE_DIR_BIT] != dir_q);
        clamp_len = (len_q < sel_count) ? len_q : sel_count;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_CHECK;
            ST_CHECK: state_d = reject ? ST_IDLE : ST_BUSY;
            ST_BUSY:  if (cmd_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request and command field capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '0;
            dir_q  <= 1'b0;
            len_q  <= '0;
            addr_q <= '0;
            xlen_q <= '0;
        end else begin
            if ((state_q == ST_IDLE) && req_valid) begin
                chan_q <= req_chan;
                dir_q  <= req_dir;
                len_q  <= req_len;
            end
            if ((state_q == ST_CHECK) && !reject) begin
                addr_q <= sel_addr;
                xlen_q <= clamp_len;
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready    = 1'b0;
        cmd_valid    = 1'b0;
        op           = '0;
        op_chan      = chan_q;
        unique case (state_q)
            ST_IDLE: begin
                req_ready    = 1'b1;
                op_chan      = req_chan;
                op.clr_flags = req_valid;
            end
            ST_CHECK: begin
                op.set_merr = reject;
            end
            ST_BUSY: begin
                cmd_valid = 1'b1;
                op.finish = cmd_done;
            end
            default: ;
        endcase
        err_pulse = op.set_merr;
        cmd_chan  = chan_q;
        cmd_dir   = dir_q;
        cmd_addr  = addr_q;
        cmd_len   = xlen_q;
    end

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dmacc_pkg::*;
#(
    parameter int  NUM_CH = 4,
    parameter int  DATA_W = 32,
    parameter int  ADDR_W = 12,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CH_W-1:0]   req_chan,
    input  logic              req_dir,
    input  logic [DATA_W-1:0] req_len,
    output logic              cmd_valid,
    output logic [CH_W-1:0]   cmd_chan,
    output logic              cmd_dir,
    output logic [DATA_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_len,
    input  logic              cmd_done
);

    logic                             dec_chan_hit;
    logic [CH_W-1:0]                  dec_chan;
    logic [1:0]                       dec_slot;
    logic                             dec_sum_hit;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] chan_slots [NUM_CH];
    logic [CH_W-1:0]                  op_chan;
    hw_op_t                           op;
    logic                             err_pulse;
    logic [NUM_CH-1:0]                err_sum_q;
    logic [DATA_W-1:0]                sel_mode_w;
    logic [DATA_W-1:0]                sel_count;
    logic [DATA_W-1:0]                sel_addr;

    dmacc_addr_dec #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .CH_W   (CH_W)
    ) u_dec (
        .addr     (reg_addr),
        .chan_hit (dec_chan_hit),
        .chan     (dec_chan),
        .slot     (dec_slot),
        .sum_hit  (dec_sum_hit)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic   ch_we;
        hw_op_t ch_op;
        assign ch_we = reg_we && dec_chan_hit && (dec_chan == CH_W'(n));
        assign ch_op = (op_chan == CH_W'(n)) ? op : '0;

        dmacc_chan_regs #(
            .DATA_W (DATA_W)
        ) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .sw_we   (ch_we),
            .sw_slot (dec_slot),
            .sw_data (reg_wdata),
            .op      (ch_op),
            .sub_len (cmd_len),
            .slots   (chan_slots[n])
        );
    end

    always_comb begin
        sel_mode_w = chan_slots[op_chan][SLOT_MODE];
        sel_count  = chan_slots[op_chan][SLOT_COUNT];
        sel_addr   = chan_slots[op_chan][SLOT_ADDR];
    end

    dmacc_seq #(
        .DATA_W (DATA_W),
        .CH_W   (CH_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_chan  (req_chan),
        .req_dir   (req_dir),
        .req_len   (req_len),
        .cmd_done  (cmd_done),
        .sel_mode  (sel_mode_w[1:0]),
        .sel_count (sel_count),
        .sel_addr  (sel_addr),
        .req_ready (req_ready),
        .cmd_valid (cmd_valid),
        .cmd_chan  (cmd_chan),
        .cmd_dir   (cmd_dir),
        .cmd_addr  (cmd_addr),
        .cmd_len   (cmd_len),
        .op_chan   (op_chan),
        .op        (op),
        .err_pulse (err_pulse)
    );

    // Sticky error summary, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_sum_q <= '0;
        end else if (err_pulse) begin
            err_sum_q[op_chan] <= 1'b1;
        end
    end

    // Read mux
    always_comb begin
        if (dec_chan_hit) begin
            reg_rdata = chan_slots[dec_chan][dec_slot];
        end else if (dec_sum_hit) begin
            reg_rdata = DATA_W'(err_sum_q);
        end else begin
            reg_rdata = '0;
        end
    end

endmodule

// File: rtl/dmacc_checker.sv
module dmacc_checker #(
    parameter int  NUM_CH = 4,
    parameter int  DATA_W = 32,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              cmd_valid,
    input logic              cmd_done,
    input logic [CH_W-1:0]   cmd_chan,
    input logic [DATA_W-1:0] cmd_addr,
    input logic [DATA_W-1:0] cmd_len,
    input logic [NUM_CH-1:0] err_sum
);

    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R7: command fields stay put while waiting for done
    assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_addr)
                                      && $stable(cmd_len) && $stable(cmd_chan)));

    // R8: done retires the command on that edge
    assert_done_retire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_done) |=> !cmd_valid);

    // R9: no new request accepted while a command is outstanding
    assert_busy_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !req_ready);

    // R9: acceptance drops ready on the next cycle
    assert_accept_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10: summary bits never clear outside reset
    assert_sum_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((err_sum & $past(err_sum)) == $past(err_sum)));

    // R6: at most one channel is flagged per cycle
    assert_sum_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ($countones(err_sum ^ $past(err_sum)) <= 1));

endmodule

bind dma_chan_ctrl dmacc_checker #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cmd_valid (cmd_valid),
    .cmd_done  (cmd_done),
    .cmd_chan  (cmd_chan),
    .cmd_addr  (cmd_addr),
    .cmd_len   (cmd_len),
    .err_sum   (err_sum_q)
);

// File: tb/sim_dma_chan_ctrl.sv
module sim_dma_chan_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int DW  = 32;
    localparam int AW  = 12;
    localparam int CW  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [CW-1:0] req_chan = '0;
    logic          req_dir = 1'b0;
    logic [DW-1:0] req_len = '0;
    logic          cmd_valid;
    logic [CW-1:0] cmd_chan;
    logic          cmd_dir;
    logic [DW-1:0] cmd_addr;
    logic [DW-1:0] cmd_len;
    logic          cmd_done = 1'b0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [NCH-1:0] m_sum = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_ctrl #(.NUM_CH(NCH), .DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
        .req_dir(req_dir), .req_len(req_len),
        .cmd_valid(cmd_valid), .cmd_chan(cmd_chan), .cmd_dir(cmd_dir),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_done(cmd_done)
    );

    function automatic logic [AW-1:0] sa(input int ch, input int k);
        return AW'(256 + ch*32 + k*8);
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    // Accept on first edge, check on second, sample after it
    task automatic do_req(input int ch, input logic dir, input logic [DW-1:0] len);
        @(negedge clk);
        req_valid = 1'b1; req_chan = CW'(ch); req_dir = dir; req_len = len;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        #1;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        cmd_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
        #1;
    endtask

    task automatic done_with_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        cmd_done = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        cmd_done = 1'b0; reg_we = 1'b0;
        #1;
    endtask

    function automatic logic [DW-1:0] pat(input int ch, input int k);
        return 32'hA5C3_0000 ^ DW'(ch << 8) ^ DW'(k * 17);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 req_ready", DW'(req_ready), 1);
        chk("R1 cmd_valid", DW'(cmd_valid), 0);
        for (int ch = 0; ch < NCH; ch++)
            for (int k = 0; k < 4; k++) rd_chk("R1 slot zero", sa(ch, k), 0);
        rd_chk("R1 summary zero", AW'(512), 0);

        // R2: map and ignored low address bits
        for (int ch = 0; ch < NCH; ch++)
            for (int k = 0; k < 4; k++) wr(sa(ch, k) | AW'(2), pat(ch, k));
        for (int ch = 0; ch < NCH; ch++)
            for (int k = 0; k < 4; k++) rd_chk("R2 readback", sa(ch, k) | AW'(1), pat(ch, k));

        // R3: summary read-only
        wr(AW'(512), 32'hFFFF_FFFF);
        rd_chk("R3 summary write ignored", AW'(512), 0);
        rd_chk("R3 summary low bits", AW'(515), 0);

        // R4: unmapped offsets
        wr(AW'('h104), 32'hDEAD_0001);
        wr(AW'('h180), 32'hDEAD_0002);
        wr(AW'('h300), 32'hDEAD_0003);
        wr(AW'('h008), 32'hDEAD_0004);
        rd_chk("R4 gap read", AW'('h104), 0);
        rd_chk("R4 past window", AW'('h180), 0);
        rd_chk("R4 far read", AW'('h300), 0);
        rd_chk("R4 low read", AW'('h008), 0);
        rd_chk("R4 ch0 slot0 intact", sa(0, 0), pat(0, 0));
        rd_chk("R4 ch0 slot1 intact", sa(0, 1), pat(0, 1));
        rd_chk("R4 ch3 slot3 intact", sa(3, 3), pat(3, 3));

        // Sweep: channel x enable x mode dir x request dir x clamp case
        for (int ch = 0; ch < NCH; ch++)
        for (int en = 0; en < 2; en++)
        for (int md = 0; md < 2; md++)
        for (int rq = 0; rq < 2; rq++)
        for (int lc = 0; lc < 2; lc++) begin
            logic [DW-1:0] base, cnt, ad, len, xl;
            bit ok;
            base = DW'(en) | DW'(md << 1);
            cnt  = DW'(100 + ch*7 + en*3 + rq);
            ad   = DW'(32'h1000 * (ch + 1) + en*16 + md*4 + rq*64);
            len  = (lc != 0) ? cnt + 5 : DW'(37 + ch);
            xl   = (lc != 0) ? cnt : len;
            ok   = (en == 1) && (md == rq);
            wr(sa(ch, 1), base | 32'h700);
            wr(sa(ch, 2), cnt);
            wr(sa(ch, 3), ad);
            do_req(ch, rq[0], len);
            if (ok) begin
                chk("R7 cmd_valid up", DW'(cmd_valid), 1);
                chk("R9 ready low busy", DW'(req_ready), 0);
                chk("R7 cmd_chan", DW'(cmd_chan), DW'(ch));
                chk("R7 cmd_dir", DW'(cmd_dir), DW'(rq));
                chk("R7 cmd_addr", cmd_addr, ad);
                chk("R7 cmd_len clamp", cmd_len, xl);
                rd_chk("R5 flags cleared", sa(ch, 1), base);
                repeat (ch) @(negedge clk);
                #1;
                chk("R7 held valid", DW'(cmd_valid), 1);
                chk("R7 held len", cmd_len, xl);
                pulse_done();
                chk("R8 cmd_valid drop", DW'(cmd_valid), 0);
                chk("R9 ready back", DW'(req_ready), 1);
                rd_chk("R8 tc set", sa(ch, 1), base | 32'h100);
                rd_chk("R8 count dec", sa(ch, 2), cnt - xl);
                rd_chk("R8 addr kept", sa(ch, 3), ad);
            end else begin
                m_sum[ch] = 1'b1;
                chk("R6 no command", DW'(cmd_valid), 0);
                chk("R9 ready after reject", DW'(req_ready), 1);
                rd_chk("R6 merr flag", sa(ch, 1), base | 32'h200);
                rd_chk("R6 R10 summary", AW'(512), DW'(m_sum));
                rd_chk("R6 count kept", sa(ch, 2), cnt);
            end
        end

        // R11: same-cycle software write wins
        wr(sa(2, 1), 32'h1);
        wr(sa(2, 2), 32'd50);
        wr(sa(2, 3), 32'h2222);
        do_req(2, 1'b0, 32'd10);
        chk("R11 setup cmd", DW'(cmd_valid), 1);
        done_with_write(sa(2, 2), 32'd77);
        rd_chk("R11 count write wins", sa(2, 2), 32'd77);
        rd_chk("R11 tc still set", sa(2, 1), 32'h101);
        do_req(2, 1'b0, 32'd10);
        chk("R11 second cmd len", cmd_len, 32'd10);
        done_with_write(sa(2, 1), 32'h3);
        rd_chk("R11 mode write wins", sa(2, 1), 32'h3);
        rd_chk("R11 count decremented", sa(2, 2), 32'd67);

        // R10: only reset clears the summary
        rd_chk("R10 summary kept", AW'(512), DW'(m_sum));
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_chk("R10 summary cleared", AW'(512), 0);
        rd_chk("R1 count after reset", sa(2, 2), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule